// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the register exchange between a host bus and the local microcontroller of an 8042-style keyboard controller. The host writes bytes into an 8-bit input buffer. The local CPU writes bytes into an 8-bit output buffer. Both sides see an 8-bit status register that carries the buffer-full flags, a command/data marker and five bits the local CPU may use freely.

A host write to either host address loads the input buffer. It sets the input-full flag and records whether the byte was a command or data, taken from the host address line. The local CPU empties that buffer with a read strobe. A local write to the output buffer sets the output-full flag and can raise the host interrupt. A host read of the data address empties the buffer again. If the local CPU is halted, a host write produces a one-cycle wake pulse. Every strobe is a single-cycle pulse, synchronous to `clk`.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the status register (as seen on `l_status` and on `h_rdata` with `h_a2`=1) is 0x00, and `kirq`, `l_ibf_irq` and `wake` are low.
- R2: A host write (`h_wr`) loads `h_wdata` into the input buffer, visible on `l_in_byte` the cycle after. It also sets IBF, which is status bit 1.
- R3: On every host write, status bit 3 (C/D) takes the value of `h_a2`: 1 marks a command, 0 marks data.
- R4: A local read strobe `l_rd_in` clears IBF. If a host write happens in the same cycle, IBF stays set.
- R5: A local write `l_wr_out` loads `l_wdata` into the output buffer and sets OBF, which is status bit 0. While `h_a2`=0, `h_rdata` shows the output buffer.
- R6: A host read with `h_a2`=0 clears OBF. A host read with `h_a2`=1 leaves OBF unchanged. A local write in the same cycle as a host data read leaves OBF set.
- R7: A local status write `l_wr_stat` copies `l_wdata` bits 7, 6, 5, 4 and 2 into the same status bits. Status bits 0, 1 and 3 are unaffected, and no host access changes the user bits.
- R8: `l_ibf_irq` is high exactly while IBF is set and `ibf_irq_en` is high.
- R9: `kirq` is high exactly while OBF is set and `kirq_en` is high.
- R10: `wake` pulses high for one cycle, the cycle after a host write made while `l_stopped` is high. It stays low at all other times.
- R11: A host write while IBF is already set replaces the input buffer contents.
- R12: While `h_a2`=1, `h_rdata` returns the full status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_a2 | input | 1 | Host address bit: 0 data port, 1 command/status port |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (output buffer or status) |
| kirq | output | 1 | Host interrupt, output buffer full |
| kirq_en | input | 1 | Host interrupt enable |
| l_wr_out | input | 1 | Local CPU write of the output buffer |
| l_rd_in | input | 1 | Local CPU read of the input buffer |
| l_wr_stat | input | 1 | Local CPU write of the user status bits |
| l_wdata | input | 8 | Local CPU write data |
| l_in_byte | output | 8 | Input buffer contents for the local CPU |
| l_status | output | 8 | Status register for the local CPU |
| ibf_irq_en | input | 1 | Local input-full interrupt enable |
| l_ibf_irq | output | 1 | Local input-full interrupt |
| l_stopped | input | 1 | Local CPU is halted |
| wake | output | 1 | One-cycle wake pulse to the local CPU |

## Verification
The hardest cases to reach are the two same-cycle collisions. One is a host write landing in the cycle the local CPU empties the input buffer. The other is a local write landing in the cycle the host drains the output buffer. In each case the flag must end up set. The bench drives both strobes from the same falling edge, so they meet at one rising edge, and then checks the flag. It also sweeps all 256 byte values through each buffer and through the user status bits. While doing so it varies the address line and the interrupt enables with the bits of the swept value.

// File: rtl/kbc_mailbox.sv
module kbc_mailbox (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h_wr,
  input  logic       h_rd,
  input  logic       h_a2,
  input  logic [7:0] h_wdata,
  output logic [7:0] h_rdata,
  output logic       kirq,
  input  logic       kirq_en,
  input  logic       l_wr_out,
  input  logic       l_rd_in,
  input  logic       l_wr_stat,
  input  logic [7:0] l_wdata,
  output logic [7:0] l_in_byte,
  output logic [7:0] l_status,
  input  logic       ibf_irq_en,
  output logic       l_ibf_irq,
  input  logic       l_stopped,
  output logic       wake
);
  logic [7:0] in_q, out_q;
  logic       ibf_q, obf_q, cd_q, wake_q;
  logic [4:0] ud_q;

  wire host_data_rd = h_rd && !h_a2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q   <= '0;
      out_q  <= '0;
      ibf_q  <= 1'b0;
      obf_q  <= 1'b0;
      cd_q   <= 1'b0;
      ud_q   <= '0;
      wake_q <= 1'b0;
    end else begin
      if (h_wr) begin
        in_q <= h_wdata;
        cd_q <= h_a2;
      end
      if (h_wr)         ibf_q <= 1'b1;
      else if (l_rd_in) ibf_q <= 1'b0;
      if (l_wr_out) begin
        out_q <= l_wdata;
        obf_q <= 1'b1;
      end else if (host_data_rd) begin
        obf_q <= 1'b0;
      end
      if (l_wr_stat) ud_q <= {l_wdata[7:4], l_wdata[2]};
      wake_q <= h_wr && l_stopped;
    end
  end

  assign l_status  = {ud_q[4:1], cd_q, ud_q[0], ibf_q, obf_q};
  assign l_in_byte = in_q;
  assign h_rdata   = h_a2 ? l_status : out_q;
  assign kirq      = obf_q && kirq_en;
  assign l_ibf_irq = ibf_q && ibf_irq_en;
  assign wake      = wake_q;
endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       h_wr,
  input logic       h_rd,
  input logic       h_a2,
  input logic [7:0] h_wdata,
  input logic [7:0] h_rdata,
  input logic       kirq,
  input logic       kirq_en,
  input logic       l_wr_out,
  input logic       l_rd_in,
  input logic       l_wr_stat,
  input logic [7:0] l_wdata,
  input logic [7:0] l_in_byte,
  input logic [7:0] l_status,
  input logic       ibf_irq_en,
  input logic       l_ibf_irq,
  input logic       l_stopped,
  input logic       wake
);
  AST_IBF_SET:   assert property (@(posedge clk) disable iff (!rst_n) h_wr |=> l_status[1] && l_in_byte == $past(h_wdata)); // R2
  AST_CMD_FLAG:  assert property (@(posedge clk) disable iff (!rst_n) h_wr |=> l_status[3] == $past(h_a2)); // R3
  AST_IBF_CLR:   assert property (@(posedge clk) disable iff (!rst_n) l_rd_in && !h_wr |=> !l_status[1]); // R4
  AST_OBF_SET:   assert property (@(posedge clk) disable iff (!rst_n) l_wr_out |=> l_status[0]); // R5
  AST_OBF_CLR:   assert property (@(posedge clk) disable iff (!rst_n) h_rd && !h_a2 && !l_wr_out |=> !l_status[0]); // R6
  AST_STAT_RD:   assert property (@(posedge clk) disable iff (!rst_n) h_rd && h_a2 && l_status[0] |=> l_status[0]); // R6
  AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !l_wr_stat |=> (l_status & 8'hF4) == ($past(l_status) & 8'hF4)); // R7
  AST_IBF_IRQ:   assert property (@(posedge clk) disable iff (!rst_n) !ibf_irq_en |-> !l_ibf_irq); // R8
  AST_KIRQ_EN:   assert property (@(posedge clk) disable iff (!rst_n) !kirq_en |-> !kirq); // R9
  AST_WAKE:      assert property (@(posedge clk) disable iff (!rst_n) wake |-> $past(h_wr && l_stopped)); // R10
  AST_WAKE_ONE:  assert property (@(posedge clk) disable iff (!rst_n) wake && !h_wr |=> !wake); // R10
endmodule

bind kbc_mailbox kbc_mailbox_chk u_chk (.*);

// File: tb/kbc_mailbox_bench.sv
module kbc_mailbox_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_wr = 0, h_rd = 0, h_a2 = 0, kirq_en = 0;
  logic l_wr_out = 0, l_rd_in = 0, l_wr_stat = 0, ibf_irq_en = 0, l_stopped = 0;
  logic [7:0] h_wdata = 0, l_wdata = 0;
  logic [7:0] h_rdata, l_in_byte, l_status;
  logic kirq, l_ibf_irq, wake;

  int tests = 0, fails = 0;
  bit done = 0;
  logic e_ibf = 0, e_obf = 0, e_cd = 0;
  logic [7:0] e_ud = 0;

  always #10 clk = ~clk;

  kbc_mailbox u_kbc_mailbox (.*);

  function automatic logic [7:0] e_stat();
    return (e_ud & 8'hF4) | {4'b0, e_cd, 1'b0, e_ibf, e_obf};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(logic a, logic [7:0] d);
    @(negedge clk); h_wr = 1; h_a2 = a; h_wdata = d;
    @(negedge clk); h_wr = 0; h_a2 = 0;
    e_ibf = 1; e_cd = a;
  endtask

  task automatic host_read(logic a, output logic [7:0] d);
    @(negedge clk); h_rd = 1; h_a2 = a; #1 d = h_rdata;
    @(negedge clk); h_rd = 0; h_a2 = 0;
    if (!a) e_obf = 0;
  endtask

  task automatic local_pulse(int which, logic [7:0] d);
    @(negedge clk);
    l_wdata = d;
    if (which == 0) l_wr_out = 1; else if (which == 1) l_rd_in = 1; else l_wr_stat = 1;
    @(negedge clk); l_wr_out = 0; l_rd_in = 0; l_wr_stat = 0;
    if (which == 0) e_obf = 1; else if (which == 1) e_ibf = 0; else e_ud = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    h_a2 = 1; #1;
    chk("R1 status", l_status, 8'h00);
    chk("R1 host status", h_rdata, 8'h00);
    chk("R1 irqs", {kirq, l_ibf_irq, wake}, 3'b000);
    h_a2 = 0;

    for (int v = 0; v < 256; v++) begin
      ibf_irq_en = v[1];
      host_write(v[0], 8'(v));
      chk("R2/R11 in byte", l_in_byte, v);
      chk("R2 ibf", l_status[1], 1);
      chk("R3 cd", l_status[3], v[0]);
      chk("R8 ibf irq", l_ibf_irq, v[1]);
      chk("R10 no wake", wake, 0);
    end
    local_pulse(1, 8'h00);
    chk("R4 ibf cleared", l_status[1], 0);
    chk("R8 irq follows ibf", l_ibf_irq, 0);

    @(negedge clk); h_wr = 1; h_wdata = 8'h5A; h_a2 = 0; l_rd_in = 1;
    @(negedge clk); h_wr = 0; l_rd_in = 0; e_ibf = 1; e_cd = 0;
    chk("R4 collision ibf", l_status[1], 1);
    chk("R11 collision data", l_in_byte, 8'h5A);

    for (int v = 0; v < 256; v++) begin
      kirq_en = v[2];
      local_pulse(0, 8'(v ^ 8'hA5));
      h_a2 = 0; #1;
      chk("R5 host data", h_rdata, v ^ 8'hA5);
      chk("R5 obf", l_status[0], 1);
      chk("R9 kirq", kirq, v[2]);
      if (v % 4 == 0) begin
        host_read(1, rd);
        chk("R12 status read", rd, e_stat());
        chk("R6 status read keeps obf", l_status[0], 1);
      end
      host_read(0, rd);
      chk("R5 read value", rd, v ^ 8'hA5);
      chk("R6 obf cleared", l_status[0], 0);
      chk("R9 kirq low", kirq, 0);
    end

    @(negedge clk); l_wdata = 8'h3C; l_wr_out = 1; h_rd = 1; h_a2 = 0;
    @(negedge clk); l_wr_out = 0; h_rd = 0; e_obf = 1;
    chk("R6 collision obf", l_status[0], 1);

    for (int v = 0; v < 256; v++) begin
      local_pulse(2, 8'(v));
      chk("R7 user bits", l_status, e_stat());
      h_a2 = 1; #1;
      chk("R12 host status", h_rdata, e_stat());
      h_a2 = 0;
    end
    host_write(1, 8'hFF);
    host_read(0, rd);
    chk("R7 host leaves user bits", l_status, e_stat());

    l_stopped = 1;
    repeat (2) @(negedge clk);
    chk("R10 idle no wake", wake, 0);
    host_write(0, 8'h11);
    chk("R10 wake pulse", wake, 1);
    @(negedge clk);
    chk("R10 wake one cycle", wake, 0);
    l_stopped = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule